// File: doc/BRIEF.md
# Two-Operand Add/Subtract Unit with Shared Flag Lines

This unit adds or subtracts two 8-bit operands and places the result on a shared main data bus. The first operand comes from a left operand bus and the second from a right operand bus. Any register may drive either operand bus, so a register can be combined with itself or used as the subtrahend. A single control input picks addition or subtraction. Subtraction adds the bitwise complement of the right operand with the carry input forced to one.

The unit drives the main bus only while its result enable is high. At all other times it releases the bus so that other sources can drive it. It produces two status signals: a signed overflow flag and a carry flag. Both go onto a small shared flag bus that other function units also drive. They are driven only while the unit is the selected flag source. Zero and sign detection are not part of this unit, because they are computed from the main bus elsewhere.

The unit is purely combinational. Its outputs follow the operand buses and controls with no clock.

Top module: `addsub_unit`

## Requirements
- R1: With the result enable high and the subtract control low, the main bus carries the low 8 bits of left + right.
- R2: With the result enable high and the subtract control high, the main bus carries the low 8 bits of left + (bitwise NOT right) + 1, which equals left − right modulo 256.
- R3: With the result enable low, the unit does not drive the main bus, and another driver's value is read back unchanged.
- R4: During addition, with the flag enable high, the carry line equals bit 8 of the 9-bit sum left + right.
- R5: During subtraction, with the flag enable high, the carry line is 1 exactly when left ≥ right as unsigned numbers, meaning no borrow occurred. The carry is not inverted for subtraction.
- R6: With the flag enable high, the overflow line is 1 exactly when bit 7 of left equals bit 7 of the effective right operand (right, or NOT right for subtraction) and bit 7 of the result differs from that shared bit.
- R7: With the flag enable low, the unit drives neither the overflow line nor the carry line, and another unit's flag values are read back unchanged.
- R8: The operand buses are independent. Subtracting equal operands gives 0 with carry 1 and overflow 0. Adding equal operands gives twice the operand modulo 256.
- R9: Subtracting zero gives the left operand unchanged with carry 1.
- R10: The flag lines are valid whenever the flag enable is high, even while the result enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_left | input | 8 | Left operand bus (first operand) |
| opnd_right | input | 8 | Right operand bus (second operand) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| result_oe | input | 1 | Drives the result onto the main bus when high |
| flag_oe | input | 1 | Drives the overflow and carry lines when high |
| main_bus | inout | 8 | Shared main data bus |
| flag_v | inout | 1 | Shared signed overflow line |
| flag_c | inout | 1 | Shared carry line (1 means no borrow during subtraction) |

## Verification
The bound checker re-evaluates the result, the carry, the no-borrow relation, the overflow sign rule and the equal-operand subtraction whenever any input changes. It does this for every combination of controls the bench applies.

Some behaviours only the bench scenarios can show:
- Releasing the shared lines is checked by a second driver on the main bus and the flag bus, whose value must read back unchanged.
- That the flags remain valid with the result bus released is checked the same way.
- The boundary operands (zero, 0x7F, 0x80, 0xFF, equal operands) are applied as directed cases.

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_left,
  input  logic [WIDTH-1:0] opnd_right,
  input  logic             sub_en,
  input  logic             result_oe,
  input  logic             flag_oe,
  inout  wire  [WIDTH-1:0] main_bus,
  inout  wire              flag_v,
  inout  wire              flag_c
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   carry;

  assign y_eff    = opnd_right ^ {WIDTH{sub_en}};
  assign carry[0] = sub_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = opnd_left[i] ^ y_eff[i] ^ carry[i];
    assign carry[i+1] = (opnd_left[i] & y_eff[i]) | (carry[i] & (opnd_left[i] ^ y_eff[i]));
  end

  assign main_bus = result_oe ? sum : {WIDTH{1'bz}};
  assign flag_c   = flag_oe ? carry[WIDTH] : 1'bz;
  assign flag_v   = flag_oe ? (carry[WIDTH] ^ carry[MSB]) : 1'bz;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opnd_left,
  input logic [WIDTH-1:0] opnd_right,
  input logic             sub_en,
  input logic             result_oe,
  input logic             flag_oe,
  input wire  [WIDTH-1:0] main_bus,
  input wire              flag_v,
  input wire              flag_c
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   add_w;
  logic [WIDTH:0]   sub_w;
  logic [WIDTH-1:0] y_inv;

  always_comb begin
    y_inv = ~opnd_right;
    add_w = {1'b0, opnd_left} + {1'b0, opnd_right};
    sub_w = {1'b0, opnd_left} + {1'b0, y_inv} + {{WIDTH{1'b0}}, 1'b1};
    if (result_oe && !sub_en)
      p_add_result_r1: assert (main_bus == add_w[MSB:0]);
    if (result_oe && sub_en)
      p_sub_result_r2: assert (main_bus == sub_w[MSB:0]);
    if (flag_oe && !sub_en)
      p_add_carry_r4: assert (flag_c == add_w[WIDTH]);
    if (flag_oe && sub_en)
      p_no_borrow_r5: assert (flag_c == (opnd_left >= opnd_right));
    if (flag_oe && !sub_en)
      p_add_ovf_r6: assert (flag_v == ((opnd_left[MSB] == opnd_right[MSB]) && (add_w[MSB] != opnd_left[MSB])));
    if (flag_oe && sub_en)
      p_sub_ovf_r6: assert (flag_v == ((opnd_left[MSB] == y_inv[MSB]) && (sub_w[MSB] != opnd_left[MSB])));
    if (result_oe && sub_en && (opnd_left == opnd_right))
      p_self_sub_r8: assert (main_bus == '0);
  end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_left (opnd_left),
  .opnd_right(opnd_right),
  .sub_en    (sub_en),
  .result_oe (result_oe),
  .flag_oe   (flag_oe),
  .main_bus  (main_bus),
  .flag_v    (flag_v),
  .flag_c    (flag_c)
);

// File: tb/test_addsub_unit.sv
`timescale 1ns/1ps
module test_addsub_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] x, y, drv_bus;
  logic       sub, roe, foe, drv_bus_en, drv_v, drv_c, drv_flag_en;
  wire  [7:0] main_bus;
  wire        flag_v, flag_c;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  assign main_bus = drv_bus_en  ? drv_bus : 8'bz;
  assign flag_v   = drv_flag_en ? drv_v   : 1'bz;
  assign flag_c   = drv_flag_en ? drv_c   : 1'bz;

  addsub_unit i_addsub_unit (
    .opnd_left(x), .opnd_right(y), .sub_en(sub), .result_oe(roe), .flag_oe(foe),
    .main_bus(main_bus), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic logic [9:0] model(input logic [7:0] a, input logic [7:0] b, input logic s);
    logic [7:0] be;
    logic [8:0] w;
    be = s ? ~b : b;
    w  = {1'b0, a} + {1'b0, be} + {8'd0, s};
    return {(a[7] == be[7]) && (w[7] != a[7]), w};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic s,
                       input logic ro, input logic fo);
    @(posedge clk);
    x = a; y = b; sub = s; roe = ro; foe = fo;
    drv_bus_en = !ro; drv_bus = 8'($urandom);
    drv_flag_en = !fo; drv_v = 1'($urandom); drv_c = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [9:0] m;
    m = model(x, y, sub);
    if (roe) chk(sub ? {tag, " R2"} : {tag, " R1"}, main_bus, m[7:0]);
    else     chk({tag, " R3"}, main_bus, drv_bus);
    if (foe) begin
      chk(sub ? {tag, " R5"} : {tag, " R4"}, {7'd0, flag_c}, {7'd0, m[8]});
      chk({tag, " R6"}, {7'd0, flag_v}, {7'd0, m[9]});
    end else begin
      chk({tag, " R7 v"}, {7'd0, flag_v}, {7'd0, drv_v});
      chk({tag, " R7 c"}, {7'd0, flag_c}, {7'd0, drv_c});
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    x = '0; y = '0; sub = 0; roe = 0; foe = 0;
    drv_bus_en = 1; drv_bus = 8'hA5; drv_flag_en = 1; drv_v = 0; drv_c = 1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R3", main_bus, 8'hA5);
    chk("reset R7", {6'd0, flag_v, flag_c}, 8'h01);

    apply(8'h7F, 8'h01, 0, 1, 1); check_all("ovf+");
    chk("R6 0x7F+1", {7'd0, flag_v}, 8'h01);
    apply(8'h80, 8'h80, 0, 1, 1); check_all("ovf-");
    chk("R4 0x80+0x80", {6'd0, flag_v, flag_c}, 8'h03);
    apply(8'hFF, 8'h01, 0, 1, 1); check_all("wrap");
    chk("R1 0xFF+1", main_bus, 8'h00);
    apply(8'h80, 8'h01, 1, 1, 1); check_all("subovf");
    chk("R6 0x80-1", {7'd0, flag_v}, 8'h01);
    apply(8'h00, 8'h01, 1, 1, 1); check_all("borrow");
    chk("R5 0-1 borrow", {6'd0, flag_v, flag_c}, 8'h00);
    apply(8'h5A, 8'h5A, 1, 1, 1);
    chk("R8 self sub", main_bus, 8'h00);
    chk("R8 self sub flags", {6'd0, flag_v, flag_c}, 8'h01);
    apply(8'h63, 8'h63, 0, 1, 1);
    chk("R8 self add", main_bus, 8'hC6);
    apply(8'h3C, 8'h00, 1, 1, 1);
    chk("R9 minus zero", main_bus, 8'h3C);
    chk("R9 carry", {7'd0, flag_c}, 8'h01);
    apply(8'hC0, 8'h50, 1, 0, 1); check_all("R10 flags only");
    chk("R10 carry", {7'd0, flag_c}, 8'h01);
    apply(8'h12, 8'h34, 0, 0, 0); check_all("released");

    for (int i = 0; i < 600; i++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      check_all("rand");
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule